// File: doc/BRIEF.md
# Data-Dependent Early-Exit Controller

This block sits beside the load/store element loop of a vector unit and decides, element by element, whether the loop continues. Each accepted element value yields a small condition field: a negative flag, a positive flag and a zero flag. The field is reported for every element that is tested. One flag is chosen by a select input and compared against a polarity bit. When the comparison marks an element as failing, the loop ends there and a new vector length is reported.

An inclusive flag decides whether the failing element is counted in the new length. For stores, the block also produces the write enable that lets each element reach memory. In non-inclusive mode, a failing store element is held back from memory even though its condition field is still reported. For loads, every tested element is written back to the register file. A typical use is a scan of a string that stops at its terminating zero, either keeping or excluding the zero.

Top module: `ffirst_data_ctl`

## Requirements
- R1: While reset is asserted and after it is released, in_ready, cr_valid, wr_en and done are 0 and vl_out is 0, until a start is accepted.
- R2: One cycle after an element is accepted (in_valid and in_ready both high at a rising edge), cr_valid is 1 and cr_idx is the element's position, counted from 0. cr_field is {neg, pos, zero, 1'b0}. Bit 3 is set when the signed data is below zero, bit 2 when it is above zero, and bit 1 when it equals zero.
- R3: test_sel picks the tested flag: 0 = neg, 1 = pos, 2 = zero, 3 = a flag that is always 0. An element fails when the picked flag XOR test_inv is 1. So test_inv = 0 fails on a set flag and test_inv = 1 fails on a clear flag.
- R4: When element i fails with incl = 1, the loop ends and vl_out becomes i + 1.
- R5: When element i fails with incl = 0, the loop ends and vl_out becomes i.
- R6: For a store (is_store = 1) with incl = 0, wr_en is 0 for the failing element. Its condition field is still reported with cr_valid = 1.
- R7: For a store with incl = 1, wr_en is 1 for the failing element, and done is reported in that same cycle.
- R8: For a load (is_store = 0), wr_en is 1 for every tested element, whether it passes or fails.
- R9: If no element among the first vl_in elements fails, vl_out becomes vl_in after the last element, and each of those elements has wr_en = 1.
- R10: Once the loop ends, in_ready stays 0 until the next start. A start that arrives while a loop runs is ignored.
- R11: A start with vl_in = 0 accepts no element. It gives done = 1 with vl_out = 0 one cycle later.
- R12: done is a one-cycle pulse that coincides with the report of the last tested element. vl_out changes only when done is 1 and holds until the next loop ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop; sampled only while idle |
| vl_in | input | VL_W | Vector length of the loop |
| is_store | input | 1 | 1 = store loop, 0 = load loop |
| test_sel | input | 2 | Flag picked for the test (R3 encoding) |
| test_inv | input | 1 | Test polarity |
| incl | input | 1 | Keep the failing element in the length |
| in_valid | input | 1 | Element data valid |
| in_ready | output | 1 | Element accepted when high with in_valid |
| in_data | input | DATA_W | Element value (loaded or to be stored) |
| cr_valid | output | 1 | Condition field valid |
| cr_field | output | 4 | Condition field of the element |
| cr_idx | output | VL_W | Position of the reported element |
| wr_en | output | 1 | Element may be written (register or memory) |
| done | output | 1 | Loop ended this cycle |
| vl_out | output | VL_W | Resulting vector length |

## Verification
Every per-element result (cr_valid, cr_field, cr_idx, wr_en) is due one cycle after the edge that accepted the element. done and vl_out arrive in that same cycle, and a zero-length start reports done one cycle after the start edge. The bench's reference model advances at each rising edge from the inputs held stable since the previous falling edge. All DUT outputs are compared with the model at the falling edge, so each result is checked in exactly the cycle in which it is due. Scenario-level checks then compare the final length and the count of enabled writes with values worked out by hand for loads and stores, both inclusive and non-inclusive, and with polarity, bubbles and a mid-loop start.

// File: rtl/ffirst_data_ctl.sv
module ffirst_data_ctl #(
  parameter int DATA_W = 32,
  parameter int VL_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl_in,
  input  logic              is_store,
  input  logic [1:0]        test_sel,
  input  logic              test_inv,
  input  logic              incl,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              cr_valid,
  output logic [3:0]        cr_field,
  output logic [VL_W-1:0]   cr_idx,
  output logic              wr_en,
  output logic              done,
  output logic [VL_W-1:0]   vl_out
);

  logic            busy;
  logic [VL_W-1:0] idx;
  logic [VL_W-1:0] vl_lim;
  logic            st_q, inv_q, incl_q;
  logic [1:0]      sel_q;

  logic       f_neg, f_zero, f_pos;
  logic [3:0] fld;
  logic       pick, fail, last, accept;

  assign f_neg  = in_data[DATA_W-1];
  assign f_zero = (in_data == '0);
  assign f_pos  = !f_neg && !f_zero;
  assign fld    = {f_neg, f_pos, f_zero, 1'b0};

  always_comb begin
    case (sel_q)
      2'd0:    pick = f_neg;
      2'd1:    pick = f_pos;
      2'd2:    pick = f_zero;
      default: pick = 1'b0;
    endcase
  end

  assign fail     = pick ^ inv_q;
  assign last     = (idx == vl_lim - 1'b1);
  assign in_ready = busy;
  assign accept   = busy && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      vl_lim   <= '0;
      st_q     <= 1'b0;
      inv_q    <= 1'b0;
      incl_q   <= 1'b0;
      sel_q    <= 2'd0;
      cr_valid <= 1'b0;
      cr_field <= 4'd0;
      cr_idx   <= '0;
      wr_en    <= 1'b0;
      done     <= 1'b0;
      vl_out   <= '0;
    end else begin
      cr_valid <= 1'b0;
      wr_en    <= 1'b0;
      done     <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (vl_in == '0) begin
            done   <= 1'b1;
            vl_out <= '0;
          end else begin
            busy   <= 1'b1;
            idx    <= '0;
            vl_lim <= vl_in;
            st_q   <= is_store;
            inv_q  <= test_inv;
            incl_q <= incl;
            sel_q  <= test_sel;
          end
        end
      end else if (accept) begin
        cr_valid <= 1'b1;
        cr_field <= fld;
        cr_idx   <= idx;
        wr_en    <= !(st_q && fail && !incl_q);
        idx      <= idx + 1'b1;
        if (fail) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          vl_out <= incl_q ? idx + 1'b1 : idx;
        end else if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          vl_out <= vl_lim;
        end
      end
    end
  end

endmodule

// File: rtl/ffirst_data_ctl_chk.sv
module ffirst_data_ctl_chk #(
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            cr_valid,
  input logic [3:0]      cr_field,
  input logic            wr_en,
  input logic            done,
  input logic [VL_W-1:0] vl_out,
  input logic [VL_W-1:0] vl_lim
);

  p_result_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> cr_valid);

  p_field_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> ($onehot(cr_field[3:1]) && !cr_field[0]));

  p_gate_only_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && !wr_en) |-> done);

  p_wr_with_cr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cr_valid);

  p_stop_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !in_ready);

  p_vl_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= vl_lim || vl_out == '0));

  p_vl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vl_out) |-> done);

endmodule

bind ffirst_data_ctl ffirst_data_ctl_chk #(.VL_W(VL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cr_valid(cr_valid), .cr_field(cr_field), .wr_en(wr_en), .done(done),
  .vl_out(vl_out), .vl_lim(vl_lim)
);

// File: tb/tb_ffirst_data_ctl.sv
module tb_ffirst_data_ctl;
  localparam int DATA_W = 32;
  localparam int VL_W   = 7;

  logic clk = 0, rst_n = 0;
  logic start = 0, is_store = 0, test_inv = 0, incl = 0, in_valid = 0;
  logic [VL_W-1:0] vl_in = '0;
  logic [1:0] test_sel = 2'd0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, cr_valid, wr_en, done;
  logic [3:0] cr_field;
  logic [VL_W-1:0] cr_idx, vl_out;

  ffirst_data_ctl #(.DATA_W(DATA_W), .VL_W(VL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .is_store(is_store),
    .test_sel(test_sel), .test_inv(test_inv), .incl(incl), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cr_valid(cr_valid), .cr_field(cr_field),
    .cr_idx(cr_idx), .wr_en(wr_en), .done(done), .vl_out(vl_out));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_busy, m_idx, m_vl, m_sel, m_v;
  bit m_st, m_inv, m_incl, m_lt, m_eq, m_gt, m_pick, m_fail;
  bit e_cr_valid, e_wr, e_done;
  int e_field, e_idx, e_vl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_idx = 0; m_vl = 0;
      e_cr_valid = 0; e_wr = 0; e_done = 0; e_field = 0; e_idx = 0; e_vl = 0;
    end else begin
      e_cr_valid = 0; e_wr = 0; e_done = 0;
      if (m_busy == 0) begin
        if (start) begin
          if (vl_in == 0) begin e_done = 1; e_vl = 0; end
          else begin
            m_busy = 1; m_idx = 0; m_vl = int'(vl_in);
            m_st = is_store; m_inv = test_inv; m_incl = incl; m_sel = int'(test_sel);
          end
        end
      end else if (in_valid) begin
        m_v = $signed(in_data);
        m_lt = m_v < 0; m_eq = m_v == 0; m_gt = m_v > 0;
        e_field = m_lt * 8 + m_gt * 4 + m_eq * 2;
        m_pick = (m_sel == 0) ? m_lt : (m_sel == 1) ? m_gt : (m_sel == 2) ? m_eq : 1'b0;
        m_fail = m_inv ? !m_pick : m_pick;
        e_cr_valid = 1; e_idx = m_idx;
        e_wr = !(m_st && m_fail && !m_incl);
        if (m_fail) begin
          m_busy = 0; e_done = 1; e_vl = m_incl ? m_idx + 1 : m_idx;
        end else if (m_idx == m_vl - 1) begin
          m_busy = 0; e_done = 1; e_vl = m_vl;
        end
        m_idx++;
      end
    end
  end

  int wrcnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready == (m_busy != 0), "R10 in_ready", in_ready, m_busy);
      chk(cr_valid == e_cr_valid, "R2 cr_valid", cr_valid, e_cr_valid);
      if (e_cr_valid) begin
        chk(cr_field == e_field, "R2 cr_field", cr_field, e_field);
        chk(cr_idx == e_idx, "R2 cr_idx", cr_idx, e_idx);
        chk(wr_en == e_wr, "R6/R8 wr_en", wr_en, e_wr);
      end else chk(wr_en == 0, "R8 wr_en idle", wr_en, 0);
      chk(done == e_done, "R12 done", done, e_done);
      chk(vl_out == e_vl, "R12 vl_out", vl_out, e_vl);
      if (cr_valid && wr_en) wrcnt++;
    end
  end

  logic [DATA_W-1:0] dat [0:7];

  task automatic run(input bit st, input int sel, input bit inv, input bit inc,
                     input int n, input bit gap, input bit poke,
                     output int got_vl, output int got_wr);
    int k, it;
    bit hs, fin;
    @(negedge clk);
    wrcnt = 0;
    start = 1; vl_in = VL_W'(n); is_store = st; test_sel = 2'(sel);
    test_inv = inv; incl = inc;
    @(negedge clk);
    start = 0;
    k = 0; it = 0; fin = done;
    while (!fin && it < 200) begin
      if (poke && it == 1) begin start = 1; vl_in = VL_W'(1); end
      else start = 0;
      in_valid = (k < n) && !(gap && (it % 2 == 1));
      in_data = (k < 8) ? dat[k] : '0;
      hs = in_valid && in_ready;
      @(negedge clk);
      if (hs) k++;
      if (done) fin = 1;
      it++;
    end
    start = 0; in_valid = 0;
    got_vl = int'(vl_out);
    @(negedge clk);
    got_wr = wrcnt;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int v, w;
  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ready && !cr_valid && !wr_en && !done && vl_out == 0, "R1 reset", vl_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!in_ready && !done && vl_out == 0, "R1 after release", in_ready, 0);

    dat[0] = 3; dat[1] = -2; dat[2] = 7; dat[3] = 0; dat[4] = 9;
    run(0, 2, 0, 0, 5, 0, 0, v, w);
    chk(v == 3, "R5 load non-incl vl", v, 3);
    chk(w == 4, "R8 load writes all tested", w, 4);
    run(0, 2, 0, 1, 5, 1, 0, v, w);
    chk(v == 4, "R4 load incl vl", v, 4);
    run(1, 2, 0, 0, 5, 0, 0, v, w);
    chk(v == 3, "R5 store non-incl vl", v, 3);
    chk(w == 3, "R6 store failing element suppressed", w, 3);
    run(1, 2, 0, 1, 5, 0, 0, v, w);
    chk(v == 4, "R7 store incl vl", v, 4);
    chk(w == 4, "R7 store failing element written", w, 4);

    dat[0] = 1; dat[1] = 2; dat[2] = 30; dat[3] = 4;
    run(1, 0, 0, 0, 4, 1, 1, v, w);
    chk(v == 4, "R9 no failure keeps vl (R10 mid-loop start ignored)", v, 4);
    chk(w == 4, "R9 all written", w, 4);
    chk(!in_ready, "R10 ready low after end", in_ready, 0);

    dat[0] = 5; dat[1] = 1; dat[2] = -3; dat[3] = 8;
    run(0, 1, 1, 0, 4, 0, 0, v, w);
    chk(v == 2, "R3 inverted polarity on pos flag", v, 2);
    run(1, 3, 1, 0, 3, 0, 0, v, w);
    chk(v == 0, "R3 always-zero flag inverted fails at 0", v, 0);
    chk(w == 0, "R6 nothing stored", w, 0);
    run(1, 3, 0, 0, 3, 0, 0, v, w);
    chk(v == 3, "R3 always-zero flag never fails", v, 3);

    run(0, 2, 0, 1, 0, 0, 0, v, w);
    chk(v == 0, "R11 zero length", v, 0);
    chk(w == 0, "R11 no element accepted", w, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule